// File: doc/BRIEF.md
# Transmit Channel Command Sequencer

This block is the control engine for a single serial transmit channel that walks a circular table of buffer descriptors. While the channel is enabled and has nothing to send, it re-examines the current descriptor on a fixed clock interval. A software demand bit can cut that wait short. A descriptor that is marked ready starts a buffer on the line. After each buffer the sequencer moves to the next table entry and looks at it straight away, so the buffers of a multi-buffer frame go out back to back. A frame ends with the buffer whose descriptor carries the last flag.

Three one-cycle command pulses steer the channel:
- **Stop** is the abrupt halt. It ends the line activity within a bounded number of bit times, flushes the transmit FIFO and freezes the descriptor pointer.
- **Graceful stop** lets the frame in progress run to its end. It then raises a sticky event flag that software clears by writing one.
- **Restart** brings a halted channel back to polling.

The descriptor memory and the serializer are seen only through simple level and strobe handshakes.

Top module: `tx_chan_cmd_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bd_ptr` is 0, `idle_line` is 1, and `bd_fetch`, `fifo_flush` and `gs_event` are 0.
- R2: While polling with `chan_en` high, `bd_fetch` goes high exactly POLL_CLKS (default 64) clocks after polling begins. While `chan_en` is low, no fetch happens.
- R3: A one-cycle `poll_now` pulse while polling makes `bd_fetch` high in the very next cycle.
- R4: `bd_fetch` is high for one cycle. If `bd_ready` is low in that cycle, the channel returns to polling with `bd_ptr` unchanged. If `bd_ready` is high, sending starts in the next cycle (`idle_line` low) and `bd_last` is captured for that buffer.
- R5: A `buf_done` pulse while sending advances `bd_ptr` by one, wrapping from RING_DEPTH-1 (default 7) to 0. In the next cycle `bd_fetch` is high, unless a graceful stop completes.
- R6: A stop pulse while sending keeps `idle_line` low until the ABORT_BITS-th (default 64) `bit_tick` after the pulse. At that tick `idle_line` rises, `fifo_flush` is high for exactly one cycle, and `bd_ptr` keeps its value. A `buf_done` during this drain is ignored.
- R7: After a stop, no fetch occurs even with `poll_now`, `bd_ptr` holds, and `idle_line` stays high until a restart.
- R8: A stop pulse while not sending halts the channel in the next cycle with a one-cycle `fifo_flush`.
- R9: A graceful-stop pulse during a frame lets every remaining buffer of that frame be sent. When the buffer flagged last finishes, `bd_ptr` advances, `gs_event` rises, `idle_line` is 1 and no further fetch occurs.
- R10: A graceful-stop pulse when no frame is in progress sets `gs_event` in the next cycle, leaves `bd_ptr` unchanged and stops polling.
- R11: A restart pulse in either halted state resumes polling. A fetch follows POLL_CLKS clocks later, or in the next cycle after a `poll_now`.
- R12: `gs_event` stays high until a `gs_event_clr` pulse. When a set and a clear fall in the same cycle, the set wins.
- R13: Commands in the same cycle are ranked stop, then graceful stop, then restart. A restart that arrives together with any other command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; gates polling |
| cmd_stop | input | 1 | Abrupt stop command pulse |
| cmd_gstop | input | 1 | Graceful stop command pulse |
| cmd_restart | input | 1 | Restart command pulse |
| poll_now | input | 1 | On-demand poll request |
| bit_tick | input | 1 | One strobe per transmitted bit |
| bd_ready | input | 1 | Current descriptor ready flag |
| bd_last | input | 1 | Current descriptor last-in-frame flag |
| buf_done | input | 1 | Serializer finished the current buffer |
| gs_event_clr | input | 1 | Write-one-to-clear for the graceful-stop event |
| bd_fetch | output | 1 | Descriptor examined this cycle |
| bd_ptr | output | $clog2(RING_DEPTH) | Current descriptor index |
| idle_line | output | 1 | Line sends idle pattern |
| fifo_flush | output | 1 | One-cycle transmit FIFO flush |
| gs_event | output | 1 | Sticky graceful-stop event flag |

## Verification
The bench counts the poll interval down to the exact edge, both at power-up and after a restart. An off-by-one timer would fetch a cycle early or late, and a timer that is not cleared would fetch early after a restart. The abort window is probed at tick 63 and tick 64, with a stray `buf_done` inserted mid-drain. A design that aborts at once, or that still advances the pointer while draining, shows up there. The bench also sends a graceful stop in the middle of a two-buffer frame, wraps the ring past entry 7, and raises all three commands together. These cases expose a sequencer that halts after the first buffer, one that leaves the pointer past the top of the ring, and one whose commands rank in the wrong order.

// File: rtl/tx_cmd_pkg.sv
package tx_cmd_pkg;

    typedef enum logic [2:0] {
        ST_POLL  = 3'd0,
        ST_FETCH = 3'd1,
        ST_SEND  = 3'd2,
        ST_HALT  = 3'd3,
        ST_GHALT = 3'd4
    } txc_state_e;

    typedef struct packed {
        logic stop_pend;   // abrupt stop waiting for the bit window
        logic gs_pend;     // graceful stop waiting for end of frame
        logic in_frame;    // a frame has started and not yet ended
        logic last;        // current buffer closes the frame
    } txc_flags_t;

    function automatic int unsigned ring_inc(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/txc_window_cnt.sv
module txc_window_cnt #(
    parameter int LIMIT = 64,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    logic [W-1:0] cnt_q;

    assign hit = inc && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/txc_ring_ptr.sv
module txc_ring_ptr import tx_cmd_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= PW'(ring_inc(32'(ptr), DEPTH));
    end
endmodule

// File: rtl/tx_chan_cmd_ctrl.sv
module tx_chan_cmd_ctrl import tx_cmd_pkg::*; #(
    parameter int RING_DEPTH = 8,
    parameter int POLL_CLKS  = 64,
    parameter int ABORT_BITS = 64,
    localparam int PTR_W = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             cmd_stop,
    input  logic             cmd_gstop,
    input  logic             cmd_restart,
    input  logic             poll_now,
    input  logic             bit_tick,
    input  logic             bd_ready,
    input  logic             bd_last,
    input  logic             buf_done,
    input  logic             gs_event_clr,
    output logic             bd_fetch,
    output logic [PTR_W-1:0] bd_ptr,
    output logic             idle_line,
    output logic             fifo_flush,
    output logic             gs_event
);
    txc_state_e st_q, st_d;
    txc_flags_t flg_q, flg_d;
    logic flush_d, gs_set, ptr_adv;
    logic poll_inc, poll_hit, go_fetch;
    logic abort_inc, abort_hit;
    logic stop_ok, gstop_ok, restart_ok;

    // poll interval timer: runs only while polling an enabled channel
    assign poll_inc = (st_q == ST_POLL) && chan_en;
    assign go_fetch = chan_en && (poll_now || poll_hit);

    txc_window_cnt #(.LIMIT(POLL_CLKS)) u_poll_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!poll_inc),
        .inc (poll_inc),
        .hit (poll_hit)
    );

    // abort window: bit times counted after an accepted stop while sending
    assign abort_inc = flg_q.stop_pend && bit_tick;

    txc_window_cnt #(.LIMIT(ABORT_BITS)) u_abort_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!flg_q.stop_pend),
        .inc (abort_inc),
        .hit (abort_hit)
    );

    txc_ring_ptr #(.DEPTH(RING_DEPTH)) u_ring_ptr (
        .clk (clk),
        .rst (rst),
        .adv (ptr_adv),
        .ptr (bd_ptr)
    );

    // command ranking: stop, then graceful stop, then restart
    assign stop_ok    = cmd_stop && (st_q != ST_HALT) && !flg_q.stop_pend;
    assign gstop_ok   = cmd_gstop && !stop_ok && !flg_q.stop_pend &&
                        (st_q inside {ST_POLL, ST_FETCH, ST_SEND});
    assign restart_ok = cmd_restart && !cmd_stop && !cmd_gstop &&
                        (st_q inside {ST_HALT, ST_GHALT});

    always_comb begin
        st_d    = st_q;
        flg_d   = flg_q;
        flush_d = 1'b0;
        gs_set  = 1'b0;
        ptr_adv = 1'b0;
        if (stop_ok && (st_q != ST_SEND)) begin
            st_d           = ST_HALT;
            flush_d        = 1'b1;
            flg_d.in_frame = 1'b0;
            flg_d.gs_pend  = 1'b0;
        end else if (stop_ok) begin
            flg_d.stop_pend = 1'b1;
        end else if (gstop_ok && !flg_q.in_frame) begin
            st_d   = ST_GHALT;
            gs_set = 1'b1;
        end else if (restart_ok) begin
            st_d = ST_POLL;
        end else begin
            if (gstop_ok)
                flg_d.gs_pend = 1'b1;
            unique case (st_q)
                ST_POLL: begin
                    if (go_fetch)
                        st_d = ST_FETCH;
                end
                ST_FETCH: begin
                    if (bd_ready) begin
                        st_d           = ST_SEND;
                        flg_d.last     = bd_last;
                        flg_d.in_frame = 1'b1;
                    end else begin
                        st_d = ST_POLL;
                    end
                end
                ST_SEND: begin
                    if (flg_q.stop_pend) begin
                        if (abort_hit) begin
                            st_d            = ST_HALT;
                            flush_d         = 1'b1;
                            flg_d.stop_pend = 1'b0;
                            flg_d.in_frame  = 1'b0;
                            flg_d.gs_pend   = 1'b0;
                        end
                    end else if (buf_done) begin
                        ptr_adv = 1'b1;
                        if (flg_q.last)
                            flg_d.in_frame = 1'b0;
                        if (flg_q.last && (flg_q.gs_pend || gstop_ok)) begin
                            st_d          = ST_GHALT;
                            gs_set        = 1'b1;
                            flg_d.gs_pend = 1'b0;
                        end else begin
                            st_d = ST_FETCH;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_POLL;
            flg_q      <= '0;
            fifo_flush <= 1'b0;
            gs_event   <= 1'b0;
        end else begin
            st_q       <= st_d;
            flg_q      <= flg_d;
            fifo_flush <= flush_d;
            if (gs_set)
                gs_event <= 1'b1;
            else if (gs_event_clr)
                gs_event <= 1'b0;
        end
    end

    assign bd_fetch  = (st_q == ST_FETCH);
    assign idle_line = (st_q != ST_SEND);

endmodule

// File: rtl/txc_cmd_chk.sv
module txc_cmd_chk #(
    parameter int RING_DEPTH = 8,
    localparam int PTR_W = $clog2(RING_DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             gs_event_clr,
    input logic             bd_fetch,
    input logic [PTR_W-1:0] bd_ptr,
    input logic             idle_line,
    input logic             fifo_flush,
    input logic             gs_event
);
    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> !fifo_flush); // R6

    AST_FLUSH_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (idle_line && !bd_fetch)); // R7

    AST_FLUSH_PTR_HELD: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (bd_ptr == $past(bd_ptr))); // R6

    AST_PTR_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (bd_ptr != $past(bd_ptr)) |->
        (bd_ptr == (($past(bd_ptr) == PTR_W'(RING_DEPTH - 1)) ? '0 : $past(bd_ptr) + 1'b1))); // R5

    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bd_fetch |=> !bd_fetch); // R4

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (gs_event && !gs_event_clr) |=> gs_event); // R12

    AST_EVENT_HALTED: assert property (@(posedge clk) disable iff (rst)
        $rose(gs_event) |-> (idle_line && !bd_fetch)); // R9
endmodule

bind tx_chan_cmd_ctrl txc_cmd_chk #(.RING_DEPTH(RING_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .gs_event_clr (gs_event_clr),
    .bd_fetch     (bd_fetch),
    .bd_ptr       (bd_ptr),
    .idle_line    (idle_line),
    .fifo_flush   (fifo_flush),
    .gs_event     (gs_event)
);

// File: tb/tx_chan_cmd_ctrl_tb.sv
module tx_chan_cmd_ctrl_tb;
    localparam int DEPTH = 8;
    localparam int POLL  = 64;
    localparam int ABORT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_en = 1'b1, cmd_stop = 1'b0, cmd_gstop = 1'b0, cmd_restart = 1'b0;
    logic poll_now = 1'b0, bit_tick = 1'b0, bd_ready = 1'b0, bd_last = 1'b0;
    logic buf_done = 1'b0, gs_event_clr = 1'b0;
    logic bd_fetch, idle_line, fifo_flush, gs_event;
    logic [2:0] bd_ptr;

    int checks = 0;
    int errors = 0;
    int exp_ptr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tx_chan_cmd_ctrl u_dut (
        .clk (clk), .rst (rst), .chan_en (chan_en),
        .cmd_stop (cmd_stop), .cmd_gstop (cmd_gstop), .cmd_restart (cmd_restart),
        .poll_now (poll_now), .bit_tick (bit_tick), .bd_ready (bd_ready),
        .bd_last (bd_last), .buf_done (buf_done), .gs_event_clr (gs_event_clr),
        .bd_fetch (bd_fetch), .bd_ptr (bd_ptr), .idle_line (idle_line),
        .fifo_flush (fifo_flush), .gs_event (gs_event)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic pulse_poll();
        poll_now = 1'b1; step(1); poll_now = 1'b0;
    endtask

    // returns number of fetches seen over n cycles
    task automatic count_fetch(int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (bd_fetch) seen++;
        end
    endtask

    // from FETCH: send one buffer, finish it; ends in FETCH or graceful halt
    task automatic send_buf(bit last, string req);
        bd_ready = 1'b1; bd_last = last; step(1);
        chk({req, " sending idle_line"}, idle_line, 0);
        bd_ready = 1'b0;
        buf_done = 1'b1; step(1); buf_done = 1'b0;
        exp_ptr = (exp_ptr + 1) % DEPTH;
        chk({req, " ptr advance"}, bd_ptr, exp_ptr);
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 ptr", bd_ptr, 0);
        chk("R1 idle", idle_line, 1);
        chk("R1 fetch", bd_fetch, 0);
        chk("R1 flush", fifo_flush, 0);
        chk("R1 event", gs_event, 0);
        rst = 1'b0;
    endtask

    task automatic t_poll_interval();
        step(POLL - 1);
        chk("R2 no fetch before interval", bd_fetch, 0);
        step(1);
        chk("R2 fetch at interval", bd_fetch, 1);
        step(1);
        chk("R4 not ready back to poll", bd_fetch, 0);
        chk("R4 ptr unchanged", bd_ptr, 0);
        pulse_poll();
        chk("R3 poll_now fetch", bd_fetch, 1);
    endtask

    task automatic t_frames_and_wrap();
        send_buf(1'b0, "R5");
        chk("R5 next fetch immediate", bd_fetch, 1);
        send_buf(1'b1, "R5");
        for (int i = 0; i < 6; i++) send_buf(1'b1, "R5 wrap");
        chk("R5 wrapped to zero", bd_ptr, 0);
        step(1);
        chk("R4 back to poll", bd_fetch, 0);
    endtask

    task automatic t_chan_disabled();
        int seen;
        chan_en = 1'b0;
        count_fetch(200, seen);
        chk("R2 disabled no fetch", seen, 0);
        chan_en = 1'b1;
        step(POLL - 1);
        chk("R2 re-enabled before interval", bd_fetch, 0);
        step(1);
        chk("R2 re-enabled fetch", bd_fetch, 1);
    endtask

    task automatic t_abort_stop();
        int seen;
        bd_ready = 1'b1; bd_last = 1'b1; step(1);
        bd_ready = 1'b0;
        chk("R6 sending", idle_line, 0);
        cmd_stop = 1'b1; step(1); cmd_stop = 1'b0;
        for (int i = 0; i < ABORT - 1; i++) begin
            bit_tick = 1'b1;
            if (i == 10) buf_done = 1'b1;
            step(1);
            bit_tick = 1'b0; buf_done = 1'b0;
            step(1);
        end
        chk("R6 still sending at tick 63", idle_line, 0);
        chk("R6 no flush yet", fifo_flush, 0);
        bit_tick = 1'b1; step(1); bit_tick = 1'b0;
        chk("R6 idle after window", idle_line, 1);
        chk("R6 flush pulse", fifo_flush, 1);
        chk("R6 ptr held", bd_ptr, exp_ptr);
        step(1);
        chk("R6 flush one cycle", fifo_flush, 0);
        poll_now = 1'b1;
        count_fetch(100, seen);
        poll_now = 1'b0;
        chk("R7 no fetch while stopped", seen, 0);
        chk("R7 ptr frozen", bd_ptr, exp_ptr);
        chk("R7 idle while stopped", idle_line, 1);
    endtask

    task automatic t_restart();
        cmd_restart = 1'b1; step(1); cmd_restart = 1'b0;
        step(POLL - 1);
        chk("R11 no fetch before interval", bd_fetch, 0);
        step(1);
        chk("R11 fetch after restart", bd_fetch, 1);
        step(1);
    endtask

    task automatic t_stop_idle_and_priority();
        int seen;
        cmd_stop = 1'b1; step(1); cmd_stop = 1'b0;
        chk("R8 flush when idle", fifo_flush, 1);
        cmd_restart = 1'b1; step(1); cmd_restart = 1'b0;
        pulse_poll();
        chk("R11 poll_now after restart", bd_fetch, 1);
        step(1);
        cmd_stop = 1'b1; cmd_gstop = 1'b1; cmd_restart = 1'b1;
        step(1);
        cmd_stop = 1'b0; cmd_gstop = 1'b0; cmd_restart = 1'b0;
        chk("R13 stop wins flush", fifo_flush, 1);
        chk("R13 no graceful event", gs_event, 0);
        cmd_restart = 1'b1; cmd_gstop = 1'b1; step(1);
        cmd_restart = 1'b0; cmd_gstop = 1'b0;
        poll_now = 1'b1;
        count_fetch(80, seen);
        poll_now = 1'b0;
        chk("R13 restart with gstop ignored", seen, 0);
        cmd_restart = 1'b1; step(1); cmd_restart = 1'b0;
    endtask

    task automatic t_graceful_idle_and_event();
        int seen;
        cmd_gstop = 1'b1; step(1); cmd_gstop = 1'b0;
        chk("R10 event set", gs_event, 1);
        chk("R10 ptr unchanged", bd_ptr, exp_ptr);
        poll_now = 1'b1;
        count_fetch(80, seen);
        poll_now = 1'b0;
        chk("R10 polling stopped", seen, 0);
        chk("R12 event held", gs_event, 1);
        gs_event_clr = 1'b1; step(1); gs_event_clr = 1'b0;
        chk("R12 event cleared", gs_event, 0);
        cmd_restart = 1'b1; step(1); cmd_restart = 1'b0;
        cmd_gstop = 1'b1; gs_event_clr = 1'b1; step(1);
        cmd_gstop = 1'b0; gs_event_clr = 1'b0;
        chk("R12 set beats clear", gs_event, 1);
        gs_event_clr = 1'b1; step(1); gs_event_clr = 1'b0;
        cmd_restart = 1'b1; step(1); cmd_restart = 1'b0;
    endtask

    task automatic t_graceful_frame();
        int seen;
        pulse_poll();
        bd_ready = 1'b1; bd_last = 1'b0; step(1);
        bd_ready = 1'b0;
        cmd_gstop = 1'b1; step(1); cmd_gstop = 1'b0;
        chk("R9 frame continues", idle_line, 0);
        buf_done = 1'b1; step(1); buf_done = 1'b0;
        exp_ptr = (exp_ptr + 1) % DEPTH;
        chk("R9 next buffer fetched", bd_fetch, 1);
        chk("R9 no event mid frame", gs_event, 0);
        send_buf(1'b1, "R9");
        chk("R9 event at frame end", gs_event, 1);
        chk("R9 idle at frame end", idle_line, 1);
        poll_now = 1'b1;
        count_fetch(80, seen);
        poll_now = 1'b0;
        chk("R9 no fetch after graceful halt", seen, 0);
    endtask

    initial begin
        t_reset();
        t_poll_interval();
        t_frames_and_wrap();
        t_chan_disabled();
        t_abort_stop();
        t_restart();
        t_stop_idle_and_priority();
        t_graceful_idle_and_event();
        t_graceful_frame();
        step(2);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule